// File: doc/BRIEF.md
# Cascadable Presettable Binary Counter

This block is a synchronous up-counter of four bits that runs through the sixteen states 0 to 15 and then returns to 0. A parallel word can be preset into it. Two separate enables gate the increment. The first is a local enable. The second is a chain enable, and it also qualifies the carry output. This split lets a carry ripple between stages through a single gate per stage, while every stage still shares the local enable. Any number of these counters can therefore be chained into one wide synchronous counter: each stage's carry output feeds the next stage's chain enable.

The reset input is active low. One elaboration parameter picks how it acts. It can clear the state at once, without waiting for a clock edge, or it can clear the state on the next rising edge like any other synchronous operation. Every other change of the count happens on the rising clock edge. Reset has the highest priority, then preset, then increment, then hold.

Top module: `presettable_counter`

## Requirements
- R1: With `RESET_ASYNC` = 0, a low `rst_n` makes `count` read 0 after the next rising edge. It wins over a low `load_n` and over both enables being high.
- R2: With `RESET_ASYNC` = 1, a low `rst_n` clears `count` to 0 immediately, with no clock edge. `count` stays 0 while `rst_n` is low. After `rst_n` is released, the first rising edge with both enables high gives `count` = 1.
- R3: When `rst_n` is high and `load_n` is low, the next rising edge copies `din` into `count`, whatever the two enables are.
- R4: When `rst_n` and `load_n` are high and `en_par` and `en_chain` are both high, each rising edge adds one to `count`.
- R5: When `rst_n` and `load_n` are high and `en_par` or `en_chain` is low, `count` keeps its value across the edge.
- R6: An increment from 15 gives 0.
- R7: `carry_out` is a combinational output. It is 1 exactly when `en_chain` is 1 and `count` is 15. `load_n` and `en_par` have no effect on it.
- R8: In a chain of three stages, each stage's `carry_out` drives the next stage's `en_chain`, and all stages share `rst_n`, `load_n` and `en_par`. The chain then counts modulo 4096, with stage 0 as the least significant digit. The last stage's `carry_out` is 1 only at 4095 with the first stage's `en_chain` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset; its style is chosen by `RESET_ASYNC` |
| load_n | input | 1 | Active-low preset enable |
| en_par | input | 1 | Local count enable |
| en_chain | input | 1 | Chain count enable; also qualifies `carry_out` |
| din | input | 4 | Preset word |
| count | output | 4 | Present count |
| carry_out | output | 1 | Terminal state reached with `en_chain` high |

## Verification
The bench goes after the priority boundaries.

- A synchronous reset asserted together with a preset must clear the counter. A design that ranked preset first would load the word instead.
- A preset asserted with both enables high must load. An inverted order would increment.
- The wrap from 15 is checked directly. A counter wider than four bits, or one that saturates, would read 16 or stay at 15.
- `carry_out` is observed at 15 with `load_n` low and with `en_chain` low. A carry gated by the preset, or left ungated, shows up at the output.
- For the asynchronous style, the count is sampled between clock edges just after reset falls, which exposes a clear that waits for the clock.
- A three-stage chain is compared with a 12-bit model through a full wrap and through scattered enable drops. A stage that ignored its chain enable would run ahead of the model.

// File: rtl/cntr_pkg.sv
package cntr_pkg;

    typedef enum logic [1:0] {
        OP_CLEAR = 2'd0,
        OP_LOAD  = 2'd1,
        OP_STEP  = 2'd2,
        OP_KEEP  = 2'd3
    } cnt_op_e;

    typedef struct packed {
        logic clear_req;
        logic load_req;
        logic step_ok;
    } cnt_ctrl_t;

    // Fixed precedence: clear, then load, then step, then keep.
    function automatic cnt_op_e resolve_op(input cnt_ctrl_t c);
        cnt_op_e op;
        if (c.clear_req)     op = OP_CLEAR;
        else if (c.load_req) op = OP_LOAD;
        else if (c.step_ok)  op = OP_STEP;
        else                 op = OP_KEEP;
        return op;
    endfunction

endpackage

// File: rtl/cntr_op_decode.sv
module cntr_op_decode
    import cntr_pkg::*;
#(
    parameter bit RESET_ASYNC = 1'b0
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    load_n,
    input  logic    en_par,
    input  logic    en_chain,
    output cnt_op_e op
);
    cnt_ctrl_t ctrl;

    always_comb begin
        // In the asynchronous style the flop itself clears; the decoder never asks for it.
        ctrl.clear_req = (RESET_ASYNC == 1'b0) && !rst_n;
        ctrl.load_req  = !load_n;
        ctrl.step_ok   = en_par && en_chain;
        op             = resolve_op(ctrl);
    end

    // R3: preset outranks counting whenever reset is inactive
    a_r3_load_beats_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_n) |-> (op == OP_LOAD));

    // R5: a dropped enable never selects the step operation
    a_r5_no_step_without_both: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_par || !en_chain) |-> (op != OP_STEP));

endmodule

// File: rtl/cntr_next.sv
module cntr_next
    import cntr_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  cnt_op_e          op,
    input  logic [WIDTH-1:0] cur,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] nxt
);
    always_comb begin
        unique case (op)
            OP_CLEAR: nxt = '0;
            OP_LOAD:  nxt = din;
            OP_STEP:  nxt = cur + WIDTH'(1);
            default:  nxt = cur;
        endcase
    end
endmodule

// File: rtl/cntr_state.sv
module cntr_state #(
    parameter int WIDTH       = 4,
    parameter bit RESET_ASYNC = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] nxt,
    output logic [WIDTH-1:0] q
);
    generate
        if (RESET_ASYNC) begin : g_async
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) q <= '0;
                else        q <= nxt;
            end
        end else begin : g_sync
            always_ff @(posedge clk) begin
                q <= nxt;
            end
        end
    endgenerate
endmodule

// File: rtl/cntr_carry.sv
module cntr_carry #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] q,
    input  logic             en_chain,
    output logic             carry
);
    always_comb carry = en_chain && (&q);
endmodule

// File: rtl/presettable_counter.sv
module presettable_counter
    import cntr_pkg::*;
#(
    parameter int WIDTH       = 4,
    parameter bit RESET_ASYNC = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_n,
    input  logic             en_par,
    input  logic             en_chain,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] count,
    output logic             carry_out
);
    localparam logic [WIDTH-1:0] TOP_VAL = {WIDTH{1'b1}};

    cnt_op_e          op;
    logic [WIDTH-1:0] nxt;

    cntr_op_decode #(.RESET_ASYNC(RESET_ASYNC)) u_decode (
        .clk(clk), .rst_n(rst_n), .load_n(load_n),
        .en_par(en_par), .en_chain(en_chain), .op(op)
    );

    cntr_next #(.WIDTH(WIDTH)) u_next (
        .op(op), .cur(count), .din(din), .nxt(nxt)
    );

    cntr_state #(.WIDTH(WIDTH), .RESET_ASYNC(RESET_ASYNC)) u_state (
        .clk(clk), .rst_n(rst_n), .nxt(nxt), .q(count)
    );

    cntr_carry #(.WIDTH(WIDTH)) u_carry (
        .q(count), .en_chain(en_chain), .carry(carry_out)
    );

    // R3: preset word appears one edge later
    a_r3_load_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_n) |=> (count == $past(din)));

    // R4: counting adds exactly one
    a_r4_step_by_one: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && en_par && en_chain) |=> (count == ($past(count) + WIDTH'(1))));

    // R5: hold keeps the value
    a_r5_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && !(en_par && en_chain)) |=> $stable(count));

    // R6: top value rolls to zero
    a_r6_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && en_par && en_chain && count == TOP_VAL) |=> (count == '0));

    // R7: carry only at top value with chain enable
    a_r7_carry_gated: assert property (@(posedge clk) disable iff (!rst_n)
        carry_out |-> (en_chain && count == TOP_VAL));

endmodule

// File: tb/chain_of_counters.sv
module chain_of_counters #(
    parameter int STAGES = 3,
    parameter int W      = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load_n,
    input  logic                en_par,
    input  logic                en_first,
    input  logic [STAGES*W-1:0] din,
    output logic [STAGES*W-1:0] value,
    output logic                carry_last
);
    logic [STAGES:0] link;
    assign link[0]    = en_first;
    assign carry_last = link[STAGES];

    for (genvar k = 0; k < STAGES; k++) begin : g_stage
        presettable_counter #(.WIDTH(W), .RESET_ASYNC(1'b0)) u_cnt (
            .clk(clk), .rst_n(rst_n), .load_n(load_n), .en_par(en_par),
            .en_chain(link[k]), .din(din[k*W +: W]),
            .count(value[k*W +: W]), .carry_out(link[k+1])
        );
    end
endmodule

// File: tb/test_presettable_counter.sv
module test_presettable_counter;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int errors = 0;

    // shared controls for the two single-stage instances
    logic       rst_s = 1'b0, rst_a = 1'b0;
    logic       load_n = 1'b1, en_par = 1'b0, en_chain = 1'b0;
    logic [3:0] din = 4'd0;
    logic [3:0] cnt_s, cnt_a;
    logic       car_s, car_a;

    // chain controls
    logic        c_rst = 1'b0, c_load = 1'b1, c_par = 1'b0, c_tr = 1'b0;
    logic [11:0] c_din = 12'd0;
    logic [11:0] c_val;
    logic        c_car;

    logic [3:0]  exp_s = 4'd0, exp_a = 4'd0;
    logic [11:0] exp_c = 12'd0;

    presettable_counter #(.WIDTH(4), .RESET_ASYNC(1'b0)) i_presettable_counter (
        .clk(clk), .rst_n(rst_s), .load_n(load_n), .en_par(en_par),
        .en_chain(en_chain), .din(din), .count(cnt_s), .carry_out(car_s)
    );

    presettable_counter #(.WIDTH(4), .RESET_ASYNC(1'b1)) i_presettable_counter_async (
        .clk(clk), .rst_n(rst_a), .load_n(load_n), .en_par(en_par),
        .en_chain(en_chain), .din(din), .count(cnt_a), .carry_out(car_a)
    );

    chain_of_counters #(.STAGES(3), .W(4)) i_chain (
        .clk(clk), .rst_n(c_rst), .load_n(c_load), .en_par(c_par),
        .en_first(c_tr), .din(c_din), .value(c_val), .carry_last(c_car)
    );

    task automatic chk(input string req, input logic [11:0] act, input logic [11:0] exp_v);
        checks++;
        if (act !== exp_v) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp_v);
        end
    endtask

    // advance one edge, updating the reference models from the pre-edge inputs
    task automatic step();
        logic [3:0]  ns, na;
        logic [11:0] nc;
        if (!rst_s)                    ns = 4'd0;
        else if (!load_n)              ns = din;
        else if (en_par && en_chain)   ns = exp_s + 4'd1;
        else                           ns = exp_s;
        if (!rst_a)                    na = 4'd0;
        else if (!load_n)              na = din;
        else if (en_par && en_chain)   na = exp_a + 4'd1;
        else                           na = exp_a;
        if (!c_rst)                    nc = 12'd0;
        else if (!c_load)              nc = c_din;
        else if (c_par && c_tr)        nc = exp_c + 12'd1;
        else                           nc = exp_c;
        @(posedge clk);
        #1;
        exp_s = ns; exp_a = na; exp_c = nc;
    endtask

    task automatic t_reset();
        rst_s = 1'b0; rst_a = 1'b0; c_rst = 1'b0;
        step(); step();
        chk("R1 reset state sync", {8'd0, cnt_s}, 12'd0);
        chk("R2 reset state async", {8'd0, cnt_a}, 12'd0);
        chk("R7 carry at reset", {11'd0, car_s}, 12'd0);
        rst_s = 1'b1; rst_a = 1'b1; c_rst = 1'b1;
        step();
    endtask

    task automatic t_load();
        load_n = 1'b0; din = 4'hA; en_par = 1'b0; en_chain = 1'b0;
        step();
        chk("R3 load idle enables", {8'd0, cnt_s}, {8'd0, exp_s});
        din = 4'h5; en_par = 1'b1; en_chain = 1'b1;
        step();
        chk("R3 load beats count", {8'd0, cnt_s}, 12'h005);
        chk("R3 load async inst", {8'd0, cnt_a}, 12'h005);
        load_n = 1'b1;
    endtask

    task automatic t_count();
        en_par = 1'b1; en_chain = 1'b1;
        for (int i = 0; i < 4; i++) begin
            step();
            chk("R4 increment", {8'd0, cnt_s}, {8'd0, exp_s});
        end
        chk("R4 reached 9", {8'd0, cnt_s}, 12'h009);
    endtask

    task automatic t_hold();
        en_par = 1'b0; en_chain = 1'b1;
        step(); step();
        chk("R5 hold par low", {8'd0, cnt_s}, 12'h009);
        en_par = 1'b1; en_chain = 1'b0;
        step();
        chk("R5 hold chain low", {8'd0, cnt_s}, 12'h009);
        chk("R5 hold async inst", {8'd0, cnt_a}, 12'h009);
    endtask

    task automatic t_wrap_carry();
        load_n = 1'b0; din = 4'hE; en_par = 1'b0; en_chain = 1'b1;
        step();
        chk("R7 no carry at 14", {11'd0, car_s}, 12'd0);
        din = 4'hF;
        step();
        // state 15 with load_n still low: carry follows only en_chain
        chk("R7 carry with load low", {11'd0, car_s}, 12'd1);
        en_chain = 1'b0; #1;
        chk("R7 carry chain low", {11'd0, car_s}, 12'd0);
        en_chain = 1'b1; #1;
        chk("R7 carry comb return", {11'd0, car_s}, 12'd1);
        load_n = 1'b1; en_par = 1'b1;
        step();
        chk("R6 wrap to zero", {8'd0, cnt_s}, 12'd0);
        chk("R6 wrap async inst", {8'd0, cnt_a}, 12'd0);
        chk("R7 carry drop after wrap", {11'd0, car_s}, 12'd0);
    endtask

    task automatic t_sync_reset_priority();
        step(); step(); step();
        load_n = 1'b0; din = 4'h9; en_par = 1'b1; en_chain = 1'b1;
        rst_s = 1'b0;
        #2;
        chk("R1 sync waits for edge", {8'd0, cnt_s}, 12'h003);
        step();
        chk("R1 sync reset beats load", {8'd0, cnt_s}, 12'd0);
        rst_s = 1'b1; load_n = 1'b1;
        step();
        chk("R1 count after release", {8'd0, cnt_s}, 12'd1);
    endtask

    task automatic t_async_reset();
        en_par = 1'b1; en_chain = 1'b1; load_n = 1'b1;
        step(); step();
        #2;
        rst_a = 1'b0;
        #1;
        chk("R2 immediate clear", {8'd0, cnt_a}, 12'd0);
        exp_a = 4'd0;
        step();
        chk("R2 held while low", {8'd0, cnt_a}, 12'd0);
        #2; rst_a = 1'b1;
        step();
        chk("R2 first edge after release", {8'd0, cnt_a}, 12'd1);
    endtask

    task automatic t_chain();
        c_load = 1'b0; c_din = 12'hFF0; c_par = 1'b1; c_tr = 1'b1;
        step();
        chk("R8 chain preset", c_val, 12'hFF0);
        c_load = 1'b0;
        c_load = 1'b1;
        for (int i = 0; i < 4200; i++) begin
            c_par = (i % 97 != 13);
            c_tr  = (i % 211 != 50);
            #1;
            chk("R8 chain carry", {11'd0, c_car}, {11'd0, (c_tr && exp_c == 12'hFFF)});
            step();
            chk("R8 chain value", c_val, exp_c);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #1;
        t_reset();
        t_load();
        t_count();
        t_hold();
        t_wrap_carry();
        t_sync_reset_priority();
        t_async_reset();
        t_chain();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule